// File: doc/BRIEF.md
# Snapshot Performance Counter Peripheral

This block sits on a small processor's byte-wide memory bus and gives software a tear-free view of several wide counters. Four live 64-bit event counters advance on single-cycle strobes from the core: elapsed cycles, retired instructions, accepted maskable interrupts and accepted non-maskable interrupts. A free-running time base keeps wallclock time in two forms. The first is total nanoseconds. The second is a split form with whole seconds in the upper half and nanoseconds within the current second in the lower half.

Software writes any byte to the capture register. On that clock edge all six values are copied into a shadow bank. Software then writes a code to the select register and reads the chosen 64-bit shadow value one byte at a time through an eight-byte window. The live counters never stop, so every byte read belongs to one instant.

The block has no sequencing state machine. Its only control is a combinational address decode into four classes (capture, select, window, unmapped) that steers every read and write.

Top module: `snap_ctr_periph`

## Requirements
- R1: After reset the select register reads 0, and all shadow values read 0 through the window under every valid select code.
- R2: Each live event counter adds exactly one on every clock edge where its strobe is high and holds otherwise. Counting continues without a gap across capture writes.
- R3: A write of any data byte to address 0x10 copies the four event counts and both wallclock forms into the shadow bank on that edge. The values copied are those held before that edge's increment. The written data has no influence.
- R4: A shadow value stays unchanged until the next write to address 0x10, however the live counters move.
- R5: The select register at address 0x11 is eight bits wide, and what is written there reads back unchanged.
- R6: Select codes map as follows: 0 cycles, 1 instructions, 2 maskable interrupts, 3 non-maskable interrupts, 4 wallclock total nanoseconds, 5 wallclock split.
- R7: Addresses 0x18 to 0x1F form the window. Address 0x18+k returns bits 8k+7 down to 8k of the selected shadow value. Read data is combinational and valid in the same cycle as the address.
- R8: A select code of 6 or above makes all eight window bytes read 0.
- R9: Reads from the capture address (0x10) and from unmapped addresses return 0. Writes to window addresses or unmapped addresses change neither the select register nor any shadow value.
- R10: The time base adds NS_PER_CLK nanoseconds per clock edge. The split nanosecond field wraps at 1,000,000,000 and carries into the seconds field. Total nanoseconds always equal seconds × 10^9 plus the nanosecond field.
- R11: If wc_valid is low on a capture edge, both wallclock shadows are loaded with all ones, and the event-count shadows are captured normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address within the peripheral aperture |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ev_cycle | input | 1 | Cycle-count strobe |
| ev_retire | input | 1 | Instruction-retired strobe |
| ev_irq | input | 1 | Maskable interrupt accepted strobe |
| ev_nmi | input | 1 | Non-maskable interrupt accepted strobe |
| wc_valid | input | 1 | High when the wallclock time base is trustworthy |

## Verification
Read data is combinational, so a window or select byte is due in the same cycle as its address. The bench sets the address at a falling edge and samples a few nanoseconds later. A capture or select write takes effect on the next rising edge. A strobe shows up in a live count on that edge, but it becomes visible only through a later capture. For this reason the bench keeps its own reference counts, updated at each rising edge. It freezes them at the edge where it drives the capture write and compares only after that edge. Wallclock expectations come from the number of edges since reset times NS_PER_CLK. The step size is raised in the bench so that the seconds carry is reached within a few cycles.

// File: rtl/snap_pkg.sv
package snap_pkg;
    // number of live event counters and of shadow slots
    localparam int N_EVT  = 4;
    localparam int N_SLOT = 6;

    // select codes; the window mux depends on this order
    typedef enum logic [2:0] {
        SEL_CYCLES   = 3'd0,
        SEL_RETIRED  = 3'd1,
        SEL_IRQ      = 3'd2,
        SEL_NMI      = 3'd3,
        SEL_WC_TOTAL = 3'd4,
        SEL_WC_SPLIT = 3'd5
    } sel_code_e;

    // address classes produced by the decoder
    typedef enum logic [1:0] {
        AC_CAPTURE,
        AC_SELECT,
        AC_WINDOW,
        AC_UNMAPPED
    } addr_class_e;
endpackage

// File: rtl/event_counters.sv
module event_counters #(
    parameter int N     = 4,
    parameter int CNT_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              strobe,
    output logic [N-1:0][CNT_W-1:0]   count
);
    for (genvar g = 0; g < N; g++) begin : g_ctr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                count[g] <= '0;
            else if (strobe[g])
                count[g] <= count[g] + 1'b1;
        end

        assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe[g] |=> $stable(count[g]));
        assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[g] |=> count[g] == $past(count[g]) + 1'b1);
    end
endmodule

// File: rtl/wallclock_base.sv
module wallclock_base #(
    parameter int          CNT_W      = 64,
    parameter int unsigned NS_PER_CLK = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] total_ns,
    output logic [CNT_W-1:0] split_time
);
    localparam int HALF = CNT_W / 2;
    localparam logic [HALF:0] STEP   = (HALF+1)'(NS_PER_CLK);
    localparam logic [HALF:0] NS_SEC = (HALF+1)'(1_000_000_000);

    logic [HALF-1:0]  sec_q, nsec_q;
    logic [CNT_W-1:0] tot_q;
    logic [HALF:0]    nsum;

    assign nsum = {1'b0, nsec_q} + STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            nsec_q <= '0;
            tot_q  <= '0;
        end else begin
            tot_q <= tot_q + CNT_W'(NS_PER_CLK);
            if (nsum >= NS_SEC) begin
                nsec_q <= HALF'(nsum - NS_SEC);
                sec_q  <= sec_q + 1'b1;
            end else begin
                nsec_q <= nsum[HALF-1:0];
            end
        end
    end

    assign total_ns   = tot_q;
    assign split_time = {sec_q, nsec_q};

    assert_nsec_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, nsec_q} < NS_SEC);
    assert_split_consistent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tot_q == CNT_W'(sec_q) * CNT_W'(1_000_000_000) + CNT_W'(nsec_q));
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
    parameter int N_SLOT = 6,
    parameter int CNT_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           capture,
    input  logic [N_SLOT-1:0][CNT_W-1:0]   live,
    output logic [N_SLOT-1:0][CNT_W-1:0]   shadow
);
    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[g] <= '0;
            else if (capture)
                shadow[g] <= live[g];
        end

        assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !capture |=> $stable(shadow[g]));
        assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> shadow[g] == $past(live[g]));
    end
endmodule

// File: rtl/snap_ctr_periph.sv
module snap_ctr_periph #(
    parameter int          CNT_W       = 64,
    parameter int unsigned NS_PER_CLK  = 20,
    parameter logic [7:0]  OFS_CAPTURE = 8'h10,
    parameter logic [7:0]  OFS_SELECT  = 8'h11,
    parameter logic [7:0]  OFS_WINDOW  = 8'h18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ev_cycle,
    input  logic       ev_retire,
    input  logic       ev_irq,
    input  logic       ev_nmi,
    input  logic       wc_valid
);
    import snap_pkg::*;

    localparam int NBYTES = CNT_W / 8;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int SLOT_W = $clog2(N_SLOT);

    addr_class_e                   acls;
    logic [7:0]                    woff;
    logic [IDX_W-1:0]              widx;
    logic [7:0]                    sel_q;
    logic [N_EVT-1:0][CNT_W-1:0]   evt_cnt;
    logic [CNT_W-1:0]              wc_total, wc_split;
    logic [N_SLOT-1:0][CNT_W-1:0]  live, shadow;
    logic [CNT_W-1:0]              win_val;
    logic                          do_capture;

    // address decode
    assign woff = bus_addr - OFS_WINDOW;
    assign widx = woff[IDX_W-1:0];

    always_comb begin
        if (bus_addr == OFS_CAPTURE)      acls = AC_CAPTURE;
        else if (bus_addr == OFS_SELECT)  acls = AC_SELECT;
        else if (woff < 8'(NBYTES))       acls = AC_WINDOW;
        else                              acls = AC_UNMAPPED;
    end

    assign do_capture = bus_we && (acls == AC_CAPTURE);

    // select register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_we && acls == AC_SELECT)
            sel_q <= bus_wdata;
    end

    event_counters #(.N(N_EVT), .CNT_W(CNT_W)) i_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe ({ev_nmi, ev_irq, ev_retire, ev_cycle}),
        .count  (evt_cnt)
    );

    wallclock_base #(.CNT_W(CNT_W), .NS_PER_CLK(NS_PER_CLK)) i_wallclock (
        .clk        (clk),
        .rst_n      (rst_n),
        .total_ns   (wc_total),
        .split_time (wc_split)
    );

    always_comb begin
        live[SEL_CYCLES]   = evt_cnt[0];
        live[SEL_RETIRED]  = evt_cnt[1];
        live[SEL_IRQ]      = evt_cnt[2];
        live[SEL_NMI]      = evt_cnt[3];
        live[SEL_WC_TOTAL] = wc_valid ? wc_total : '1;
        live[SEL_WC_SPLIT] = wc_valid ? wc_split : '1;
    end

    shadow_bank #(.N_SLOT(N_SLOT), .CNT_W(CNT_W)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (do_capture),
        .live    (live),
        .shadow  (shadow)
    );

    // window mux
    always_comb begin
        if (sel_q < 8'(N_SLOT))
            win_val = shadow[sel_q[SLOT_W-1:0]];
        else
            win_val = '0;
    end

    // read data
    always_comb begin
        bus_rdata = '0;
        unique case (acls)
            AC_SELECT:   bus_rdata = sel_q;
            AC_WINDOW:   bus_rdata = win_val[int'(widx)*8 +: 8];
            AC_CAPTURE:  bus_rdata = '0;
            AC_UNMAPPED: bus_rdata = '0;
        endcase
    end

    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_SELECT) |=> $stable(sel_q));
    assert_sel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SELECT) |=> sel_q == $past(bus_wdata));
    assert_bad_code_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q >= 8'(N_SLOT) && acls == AC_WINDOW) |-> bus_rdata == 8'h00);
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CAPTURE || acls == AC_UNMAPPED) |-> bus_rdata == 8'h00);
    assert_invalid_wc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_capture && !wc_valid) |=> (&shadow[SEL_WC_TOTAL]) && (&shadow[SEL_WC_SPLIT]));
endmodule

// File: tb/test_snap_ctr_periph.sv
`timescale 1ns/1ps
module test_snap_ctr_periph;
    localparam int unsigned NS = 300_000_000;
    localparam logic [7:0] A_CAP = 8'h10, A_SEL = 8'h11, A_WIN = 8'h18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic ev_cycle = 1'b0, ev_retire = 1'b0, ev_irq = 1'b0, ev_nmi = 1'b0;
    logic wc_valid = 1'b1;
    logic stim_on = 1'b0;

    int n_checks = 0, n_fail = 0;

    // reference model, built from the requirements
    logic [63:0] r_cnt [4];
    logic [63:0] r_snap [6];
    longint unsigned r_edges = 0;
    int stim_ctr = 0;

    always #10 clk = ~clk;

    snap_ctr_periph #(.NS_PER_CLK(NS)) i_snap_ctr_periph (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_cycle(ev_cycle),
        .ev_retire(ev_retire), .ev_irq(ev_irq), .ev_nmi(ev_nmi), .wc_valid(wc_valid)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) r_cnt[i] = '0;
            for (int i = 0; i < 6; i++) r_snap[i] = '0;
            r_edges = 0;
        end else begin
            if (bus_we && bus_addr == A_CAP) begin
                for (int i = 0; i < 4; i++) r_snap[i] = r_cnt[i];
                if (wc_valid) begin
                    r_snap[4] = r_edges * NS;
                    r_snap[5] = {32'((r_edges * NS) / 1_000_000_000),
                                 32'((r_edges * NS) % 1_000_000_000)};
                end else begin
                    r_snap[4] = '1;
                    r_snap[5] = '1;
                end
            end
            if (ev_cycle)  r_cnt[0] = r_cnt[0] + 1;
            if (ev_retire) r_cnt[1] = r_cnt[1] + 1;
            if (ev_irq)    r_cnt[2] = r_cnt[2] + 1;
            if (ev_nmi)    r_cnt[3] = r_cnt[3] + 1;
            r_edges++;
        end
    end

    // strobe pattern driven away from the rising edge
    always @(negedge clk) begin
        if (stim_on) begin
            stim_ctr++;
            ev_cycle  <= (stim_ctr % 13) != 0;
            ev_retire <= (stim_ctr % 3) != 0;
            ev_irq    <= (stim_ctr % 7) == 0;
            ev_nmi    <= (stim_ctr % 11) == 3;
        end else begin
            ev_cycle <= 1'b0; ev_retire <= 1'b0; ev_irq <= 1'b0; ev_nmi <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic read64(input logic [7:0] code, output logic [63:0] v);
        logic [7:0] b;
        bus_write(A_SEL, code);
        for (int k = 0; k < 8; k++) begin
            bus_read(A_WIN + 8'(k), b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic t_reset;
        logic [7:0] b;
        logic [63:0] v;
        bus_read(A_SEL, b);
        chk("R1 select after reset", 64'(b), 64'h0);
        for (int c = 0; c < 6; c++) begin
            read64(8'(c), v);
            chk("R1 shadow after reset", v, 64'h0);
        end
    endtask

    task automatic t_capture_all;
        logic [63:0] v, exp [6];
        stim_on = 1'b1;
        repeat (300) @(negedge clk);
        bus_write(A_CAP, 8'hA5);
        for (int c = 0; c < 6; c++) exp[c] = r_snap[c];
        for (int c = 0; c < 6; c++) begin
            read64(8'(c), v);
            chk("R3 R6 captured value by code", v, exp[c]);
        end
        chk("R7 multi-byte cycle count", 64'(exp[0] > 255), 64'h1);
    endtask

    task automatic t_hold_and_continue;
        logic [63:0] v, first, exp;
        bus_write(A_CAP, 8'h00);
        first = r_snap[0];
        repeat (40) @(negedge clk);
        read64(8'(0), v);
        chk("R4 shadow unchanged while counting", v, first);
        bus_write(A_CAP, 8'hFF);
        exp = r_snap[0];
        read64(8'(0), v);
        chk("R2 counting continued across capture", v, exp);
        chk("R2 count advanced", 64'(v > first), 64'h1);
        read64(8'(1), v);
        chk("R2 retired count", v, r_snap[1]);
        read64(8'(2), v);
        chk("R2 irq count", v, r_snap[2]);
        read64(8'(3), v);
        chk("R2 nmi count", v, r_snap[3]);
    endtask

    task automatic t_byte_order;
        logic [7:0] b;
        logic [63:0] exp;
        bus_write(A_CAP, 8'h3C);
        exp = r_snap[4];
        bus_write(A_SEL, 8'd4);
        for (int k = 7; k >= 0; k--) begin
            bus_read(A_WIN + 8'(k), b);
            chk("R7 window byte order", 64'(b), 64'(exp[8*k +: 8]));
        end
    endtask

    task automatic t_select_rw;
        logic [7:0] b;
        bus_write(A_SEL, 8'hC3);
        bus_read(A_SEL, b);
        chk("R5 select readback C3", 64'(b), 64'hC3);
        bus_write(A_SEL, 8'h05);
        bus_read(A_SEL, b);
        chk("R5 select readback 05", 64'(b), 64'h05);
    endtask

    task automatic t_bad_code;
        logic [63:0] v;
        read64(8'd6, v);
        chk("R8 code 6 reads zero", v, 64'h0);
        read64(8'hFF, v);
        chk("R8 code FF reads zero", v, 64'h0);
    endtask

    task automatic t_unmapped;
        logic [7:0] b;
        logic [63:0] v, exp;
        bus_read(A_CAP, b);
        chk("R9 capture address reads zero", 64'(b), 64'h0);
        bus_read(8'h00, b);
        chk("R9 unmapped 00 reads zero", 64'(b), 64'h0);
        bus_read(8'h20, b);
        chk("R9 unmapped 20 reads zero", 64'(b), 64'h0);
        bus_write(A_SEL, 8'd1);
        exp = r_snap[1];
        bus_write(A_WIN + 8'd2, 8'h77);
        bus_write(8'h40, 8'h03);
        bus_read(A_SEL, b);
        chk("R9 select untouched by stray writes", 64'(b), 64'h01);
        read64(8'd1, v);
        chk("R9 shadow untouched by stray writes", v, exp);
    endtask

    task automatic t_wallclock;
        logic [63:0] v, t, s;
        bus_write(A_CAP, 8'h11);
        t = r_snap[4];
        s = r_snap[5];
        read64(8'd4, v);
        chk("R10 total ns", v, t);
        read64(8'd5, v);
        chk("R10 split form", v, s);
        chk("R10 split nsec below 1e9", 64'(v[31:0] < 32'd1_000_000_000), 64'h1);
        chk("R10 split consistent with total", 64'(v[63:32]) * 64'd1_000_000_000 + 64'(v[31:0]), t);
    endtask

    task automatic t_invalid_wc;
        logic [63:0] v, exp0;
        @(negedge clk);
        wc_valid = 1'b0;
        bus_write(A_CAP, 8'h5A);
        exp0 = r_snap[0];
        wc_valid = 1'b1;
        read64(8'd4, v);
        chk("R11 invalid total all ones", v, 64'hFFFF_FFFF_FFFF_FFFF);
        read64(8'd5, v);
        chk("R11 invalid split all ones", v, 64'hFFFF_FFFF_FFFF_FFFF);
        read64(8'd0, v);
        chk("R11 event shadow normal", v, exp0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture_all();
        t_hold_and_continue();
        t_byte_order();
        t_select_rw();
        t_bad_code();
        t_unmapped();
        t_wallclock();
        t_invalid_wc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule